// File: doc/BRIEF.md
# GPIO Port with Per-Pin Edge Interrupts

This block is a parameterised general-purpose I/O port (eight pins by default) reached through a small synchronous register bus. Software sets each pin's drive direction and output level and reads back the synchronised pin levels. Each pin has a weak pull-up, which is on only while the pin is an input and its output bit is 1. A pin that an alternate function has claimed keeps its input path. Its edge detection also stays on, but the port stops driving that pin.

Every pin input passes through a multi-flop synchroniser. An edge detector then compares the synchronised level with the sample taken one cycle earlier. A per-pin polarity bit chooses whether a rising or a falling edge counts. A detected edge sets a sticky flag. Software can also set a flag by writing 1 to it. A single interrupt request is raised while any flag is set and its enable bit is 1. The request stays up until software clears that flag or the enable.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset the direction, output, edge-polarity, flag and enable registers all read 0, `irq` is low and `pin_oe` is 0 (all pins are inputs).
- R2: Address 2 reads the pin levels after the synchroniser. It keeps doing so after a write to address 2, because such writes are ignored.
- R3: An edge-polarity bit of 0 flags a rising edge and a bit of 1 flags a falling edge. With the default two synchroniser stages, a pin change that settles before clock edge k sets its flag at edge k+2.
- R4: A flag stays set until software writes 0 to that bit. Writing 1 to a flag bit sets it.
- R5: If a detected edge and a write of 0 to the same flag bit land on the same clock edge, the flag ends up set.
- R6: `irq` is high exactly while some bit is set in both the flag and the enable register. With enable 0 it stays low, and it holds high until the flag or the enable is cleared.
- R7: `pin_out` equals the output register. `pin_oe` is direction AND NOT `pin_alt`. `pin_pu` is NOT direction AND output. `pin_pu` and `pin_oe` are never both high on one pin.
- R8: A pin with `pin_alt` high still updates the input register and still sets its flag on the selected edge.
- R9: Levels present on the pins while reset is held set no flag after reset is released.
- R10: Register map: 0 direction, 1 output, 2 input, 3 edge polarity, 4 flags, 5 enable. Other addresses read 0. `bus_rdata` shows the addressed register one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_alt | input | WIDTH | Pin is owned by an alternate function |
| pin_out | output | WIDTH | Output level per pin |
| pin_oe | output | WIDTH | Output driver enable per pin |
| pin_pu | output | WIDTH | Weak pull-up enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its defaults: WIDTH 8, SYNC_STAGES 2 and ADDR_W 3. Eight pins are enough for patterns that mix both edge polarities across bits in one vector. Two stages fix the flag latency at a known three edges. That makes it possible to place a clearing write on exactly the same edge as a detected edge. A three-bit address also leaves the unused addresses 6 and 7 to probe.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int A_DIR  = 0;
  localparam int A_OUT  = 1;
  localparam int A_IN   = 2;
  localparam int A_EDGE = 3;
  localparam int A_FLAG = 4;
  localparam int A_EN   = 5;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] fall_sel,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] hit
);
  localparam int PRIME_W = STAGES + 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]             prev;
  logic [PRIME_W-1:0]           prime;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= '0;
      prime <= '0;
    end else begin
      chain[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev  <= chain[STAGES-1];
      prime <= {prime[PRIME_W-2:0], 1'b1};
    end
  end

  assign level = chain[STAGES-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    logic rise, fall;
    assign rise   = level[i] & ~prev[i];
    assign fall   = ~level[i] & prev[i];
    assign hit[i] = prime[PRIME_W-1] & (fall_sel[i] ? fall : rise);
  end

  // R3: a reported edge always coincides with a change of the synchronised level
  p_hit_needs_change_r3: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |-> (level != $past(level)));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic             flag_we,
  input  logic             en_we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hit,
  output logic [WIDTH-1:0] sel_q,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] en_q,
  output logic             irq
);
  logic [WIDTH-1:0] flag_d;

  always_comb begin
    flag_d = flag_we ? wdata : flag_q;
    flag_d = flag_d | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      if (sel_we) sel_q <= wdata;
      if (en_we)  en_q  <= wdata;
      flag_q <= flag_d;
    end
  end

  assign irq = |(flag_q & en_q);

  // R3, R5: every detected edge leaves its flag set, whatever software wrote
  p_edge_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));
  // R4: without a flag write no set flag is lost
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R6: request holds until flag or enable is written
  p_irq_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !flag_we && !en_we) |=> irq);
  // R6: all enables clear means no request
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  pin_alt,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pu,
  output logic              irq
);
  import gpio_edge_pkg::*;

  logic [WIDTH-1:0] dir_q, out_q, level, hit, sel_q, flag_q, en_q;
  logic             wr_dir, wr_out, wr_sel, wr_flag, wr_en;

  assign wr_dir  = bus_we && (bus_addr == ADDR_W'(A_DIR));
  assign wr_out  = bus_we && (bus_addr == ADDR_W'(A_OUT));
  assign wr_sel  = bus_we && (bus_addr == ADDR_W'(A_EDGE));
  assign wr_flag = bus_we && (bus_addr == ADDR_W'(A_FLAG));
  assign wr_en   = bus_we && (bus_addr == ADDR_W'(A_EN));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_out) out_q <= bus_wdata;
    end
  end

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .fall_sel(sel_q),
    .level(level), .hit(hit));

  gpio_irq_regs #(.WIDTH(WIDTH)) i_irq (
    .clk(clk), .rst(rst), .sel_we(wr_sel), .flag_we(wr_flag), .en_we(wr_en),
    .wdata(bus_wdata), .hit(hit), .sel_q(sel_q), .flag_q(flag_q),
    .en_q(en_q), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (int'(bus_addr))
        A_DIR:   bus_rdata <= dir_q;
        A_OUT:   bus_rdata <= out_q;
        A_IN:    bus_rdata <= level;
        A_EDGE:  bus_rdata <= sel_q;
        A_FLAG:  bus_rdata <= flag_q;
        A_EN:    bus_rdata <= en_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q & ~pin_alt;
  assign pin_pu  = ~dir_q & out_q;

  // R7: a pin is never both driven and pulled up
  p_pullup_vs_drive_r7: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);
  // R1: one edge after reset direction and output are cleared
  p_dir_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (dir_q == '0 && out_q == '0 && !irq));
endmodule

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  localparam int W = 8;
  localparam int AW = 3;

  logic          clk = 0, rst = 1, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0, bus_rdata, pin_in = 8'hA5, pin_alt = '0;
  logic [W-1:0]  pin_out, pin_oe, pin_pu;
  logic          irq;
  int            checks = 0, errors = 0, cycles = 0;
  logic [W-1:0]  rv;

  // {polarity, start pins, end pins, expected flags}
  localparam logic [31:0] VEC [9] = '{
    32'h00_00_FF_FF, 32'hFF_00_FF_00, 32'hFF_FF_00_FF,
    32'h0F_0F_F0_FF, 32'h0F_F0_0F_00, 32'hAA_55_AA_00,
    32'hAA_AA_55_FF, 32'h00_3C_3C_00, 32'h00_00_81_81 };

  gpio_edge_port #(.WIDTH(W), .SYNC_STAGES(2), .ADDR_W(AW)) i_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_alt(pin_alt), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    bus_addr = AW'(a); bus_we = 0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    check("R1 irq", irq, 0);
    check("R1 pin_oe", pin_oe, 0);
    settle();
    rd(0, rv); check("R1 dir", rv, 0);
    rd(1, rv); check("R1 out", rv, 0);
    rd(3, rv); check("R1 polarity", rv, 0);
    rd(5, rv); check("R1 enable", rv, 0);
    rd(4, rv); check("R9 no flag from reset levels", rv, 0);
    rd(2, rv); check("R2 input level", rv, 8'hA5);
    wr(2, 8'h00);
    rd(2, rv); check("R2 write ignored", rv, 8'hA5);
    rd(6, rv); check("R10 unused addr 6", rv, 0);
    rd(7, rv); check("R10 unused addr 7", rv, 0);

    // R3 vector table walk with all enables on
    wr(5, 8'hFF);
    foreach (VEC[i]) begin
      wr(3, VEC[i][31:24]);
      pin_in = VEC[i][23:16];
      settle();
      wr(4, 8'h00);
      pin_in = VEC[i][15:8];
      settle();
      rd(4, rv); check($sformatf("R3 vector %0d flags", i), rv, VEC[i][7:0]);
      check($sformatf("R6 vector %0d irq", i), irq, VEC[i][7:0] != 0);
    end

    // R3 latency: flag appears at edge k+2
    wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
    pin_in = 8'h00; settle(); wr(4, 8'h00);
    wr(5, 8'h04);
    pin_in = 8'h04;
    @(negedge clk); check("R3 not yet after k", irq, 0);
    @(negedge clk); check("R3 not yet after k+1", irq, 0);
    @(negedge clk); check("R3 flag after k+2", irq, 1);
    pin_in = 8'h00; settle();
    rd(4, rv); check("R4 sticky after pin returns", rv, 8'h04);
    wr(4, 8'h00);
    rd(4, rv); check("R4 cleared by write 0", rv, 0);

    // R4 / R6 software set and masking
    wr(5, 8'h00);
    wr(4, 8'h10);
    rd(4, rv); check("R4 software set", rv, 8'h10);
    check("R6 masked", irq, 0);
    wr(5, 8'h10);
    check("R6 enabled", irq, 1);
    settle();
    check("R6 held", irq, 1);
    wr(5, 8'h00);
    check("R6 mask drops irq", irq, 0);
    wr(5, 8'h10);
    wr(4, 8'h00);
    check("R6 clear drops irq", irq, 0);

    // R5 clear write lands on same edge as detection
    wr(5, 8'h00);
    pin_in = 8'h02;
    repeat (2) @(negedge clk);
    wr(4, 8'h00);
    rd(4, rv); check("R5 edge beats clear", rv, 8'h02);
    wr(4, 8'h00);
    rd(4, rv); check("R5 later clear works", rv, 0);
    pin_in = 8'h00; settle(); wr(4, 8'h00);

    // R7 pad controls
    wr(0, 8'h0F); wr(1, 8'h33);
    check("R7 pin_out", pin_out, 8'h33);
    check("R7 pin_oe", pin_oe, 8'h0F);
    check("R7 pin_pu", pin_pu, 8'h30);
    pin_alt = 8'h03;
    #1 check("R7 alt gates oe", pin_oe, 8'h0C);
    rd(0, rv); check("R10 dir readback", rv, 8'h0F);
    rd(1, rv); check("R10 out readback", rv, 8'h33);

    // R8 alternate function keeps input and edges alive
    pin_alt = 8'hFF; wr(3, 8'h80);
    pin_in = 8'hC0; settle(); wr(4, 8'h00);
    pin_in = 8'h41; settle();
    rd(2, rv); check("R8 input with alt", rv, 8'h41);
    rd(4, rv); check("R8 flags with alt", rv, 8'h81);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule